// File: doc/BRIEF.md
# PCI parity error reporter

This block watches a 32-bit multiplexed address/data bus and checks even parity across the address/data lines, the command/byte-enable lines and the parity bit. The parity bit for a phase arrives one clock after that phase. The block is told which clocks carry an address phase and which carry a data phase, and it latches the bus command of each transaction. A parity mismatch in an address phase raises the system-error line. A mismatch in a data phase raises the parity-error line.

Both error lines are presented as an output-enable plus a driven value, so a pad ring can build the open-drain and sustained tri-state buffers from them. The system-error line is only ever pulled low, for one clock per error. The parity-error line is driven low two clocks after the bad data phase, then driven high for one clock, then released. A sticky status bit records every parity error, whether or not reporting is enabled. Software clears it with a write-one pulse.

Top module: `pci_parity_guard`

## Requirements
- R1: Parity is even: a phase is in error when the XOR of `ad`, `cbe_n` from that phase and `par` sampled on the following clock is 1. All inputs are sampled on the rising edge. A clock marked neither address nor data phase is never checked.
- R2: An address phase parity error makes `serr_oe` 1 for exactly one clock, namely the second clock after the address phase. This happens only if `par_resp_en` and `serr_en` are both 1 on the clock that carries `par`.
- R3: Whenever `serr_oe` is 1, `serr_o` is 0. The system-error line is never driven high.
- R4: A data phase parity error drives the parity-error line low (`perr_oe`=1, `perr_o`=0) in the second clock after that data phase. This happens when `par_resp_en` is 1 on the `par` clock; `serr_en` has no effect on it.
- R5: Back-to-back data phases with parity errors keep the parity-error line low for one clock per bad phase, with no high clock between them.
- R6: After the last low clock, the parity-error line is driven high (`perr_oe`=1, `perr_o`=1) for one clock and is then released (`perr_oe`=0).
- R7: An address phase whose `cbe_n` equals 4'b0001 starts a special transaction. Data phases up to the next address phase never drive the parity-error line. They still set the status bit.
- R8: `parity_err_stat` is set to 1 in the second clock after any phase with a parity error, whatever the enables. A `perr_stat_clr` pulse clears it one clock later. When a set and a clear fall on the same clock, the set wins.
- R9: While `rst_n` is 0, both output-enables are 0 and all inputs are ignored. After `rst_n` rises, no report and no status bit comes from activity seen during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase | input | 1 | This clock is an address phase |
| data_phase | input | 1 | This clock is a completed data phase |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command (address phase) or byte enables (data phase) |
| par | input | 1 | Even parity of the previous clock's `ad` and `cbe_n` |
| par_resp_en | input | 1 | Parity-response enable |
| serr_en | input | 1 | System-error reporting enable |
| perr_stat_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| perr_oe | output | 1 | Parity-error line output-enable |
| perr_o | output | 1 | Parity-error line driven value |
| serr_oe | output | 1 | System-error line output-enable (pull low) |
| serr_o | output | 1 | System-error line driven value |
| parity_err_stat | output | 1 | Sticky detected-parity-error status |

## Verification
The stimulus places bad parity on back-to-back data phases. A design that released or parked the line between errors would show a high clock where a low one belongs. It also places bad parity on data phases of a special transaction that is followed by a normal transaction. A design that kept the special mark too long, or dropped it too early, would report the wrong phases. Error pulses are aimed at enable combinations where only one enable is set, and at clocks where a status set and a clear coincide. Errors are also driven while reset is held. This exposes designs that leak reset-time activity into reports, or that report one clock early or late.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_kind_e;

   typedef struct packed {
      phase_kind_e kind;
      logic        special;
      logic        odd;
   } phase_rec_t;

endpackage

// File: rtl/ppg_parity_fold.sv
module ppg_parity_fold #(
   parameter int WIDTH   = 32,
   parameter int BY_LANE = 1
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             odd_o
);
   localparam int LANE_W = 8;
   localparam int LANES  = WIDTH / LANE_W;

   generate
      if (BY_LANE != 0) begin : g_lane
         if (WIDTH % LANE_W != 0) begin : g_bad
            $error("ppg_parity_fold: WIDTH must be a multiple of 8 in lane mode");
         end
         logic [LANES-1:0] lane_odd;
         for (genvar l = 0; l < LANES; l++) begin : g_l
            assign lane_odd[l] = ^bits_i[l*LANE_W +: LANE_W];
         end
         assign odd_o = ^lane_odd;
      end else begin : g_flat
         assign odd_o = ^bits_i;
      end
   endgenerate
endmodule

// File: rtl/ppg_phase_track.sv
module ppg_phase_track import ppg_pkg::*; #(
   parameter int CBE_W       = 4,
   parameter int SPECIAL_CMD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_phase,
   input  logic             data_phase,
   input  logic [CBE_W-1:0] cbe_n,
   input  logic             odd_now,
   output phase_rec_t       rec_q
);
   localparam logic [CBE_W-1:0] SPC = CBE_W'(SPECIAL_CMD);

   logic special_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         special_tx <= 1'b0;
         rec_q      <= '{kind: PH_IDLE, special: 1'b0, odd: 1'b0};
      end else begin
         rec_q.odd <= odd_now;
         if (addr_phase) begin
            rec_q.kind    <= PH_ADDR;
            rec_q.special <= 1'b0;
            special_tx    <= (cbe_n == SPC);
         end else if (data_phase) begin
            rec_q.kind    <= PH_DATA;
            rec_q.special <= special_tx;
         end else begin
            rec_q.kind    <= PH_IDLE;
            rec_q.special <= 1'b0;
         end
      end
   end

   // R7: data phase special mark only follows a special command
   assert_special_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_q.kind == PH_DATA && rec_q.special) |-> $past(special_tx));
endmodule

// File: rtl/ppg_perr_drive.sv
module ppg_perr_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic perr_oe,
   output logic perr_o
);
   logic low_q, park_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= 1'b0;
         park_q <= 1'b0;
      end else begin
         low_q  <= fire_i;
         park_q <= low_q && !fire_i;
      end
   end

   assign perr_oe = low_q | park_q;
   assign perr_o  = ~low_q;

   assert_park_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_oe && perr_o) |=> !(perr_oe && perr_o));
   assert_park_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_oe && perr_o) |-> $past(perr_oe && !perr_o));
endmodule

// File: rtl/ppg_serr_drive.sv
module ppg_serr_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic serr_oe,
   output logic serr_o
);
   localparam logic ASSERT_LVL = 1'b0;

   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= fire_i;
   end

   assign serr_oe = pulse_q;
   assign serr_o  = ASSERT_LVL;
endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard import ppg_pkg::*; #(
   parameter int AD_W         = 32,
   parameter int CBE_W        = 4,
   parameter int SPECIAL_CMD  = 1,
   parameter int FOLD_BY_LANE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_phase,
   input  logic             data_phase,
   input  logic [AD_W-1:0]  ad,
   input  logic [CBE_W-1:0] cbe_n,
   input  logic             par,
   input  logic             par_resp_en,
   input  logic             serr_en,
   input  logic             perr_stat_clr,
   output logic             perr_oe,
   output logic             perr_o,
   output logic             serr_oe,
   output logic             serr_o,
   output logic             parity_err_stat
);
   localparam int LANES = AD_W / 8;

   generate
      if (LANES != CBE_W || AD_W % 8 != 0) begin : g_chk_w
         $error("pci_parity_guard: one byte enable per 8 address/data bits required");
      end
      if (SPECIAL_CMD < 0 || SPECIAL_CMD >= (1 << CBE_W)) begin : g_chk_c
         $error("pci_parity_guard: SPECIAL_CMD does not fit the command field");
      end
   endgenerate

   logic       ad_odd, odd_now;
   phase_rec_t rec_q;
   logic       mismatch, addr_err, data_err, any_err;
   logic       perr_fire, serr_fire;

   ppg_parity_fold #(.WIDTH(AD_W), .BY_LANE(FOLD_BY_LANE)) u_fold (
      .bits_i (ad),
      .odd_o  (ad_odd)
   );

   assign odd_now = ad_odd ^ (^cbe_n);

   ppg_phase_track #(.CBE_W(CBE_W), .SPECIAL_CMD(SPECIAL_CMD)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_phase (addr_phase),
      .data_phase (data_phase),
      .cbe_n      (cbe_n),
      .odd_now    (odd_now),
      .rec_q      (rec_q)
   );

   assign mismatch  = rec_q.odd ^ par;
   assign addr_err  = mismatch && (rec_q.kind == PH_ADDR);
   assign data_err  = mismatch && (rec_q.kind == PH_DATA);
   assign any_err   = addr_err || data_err;
   assign perr_fire = data_err && par_resp_en && !rec_q.special;
   assign serr_fire = addr_err && par_resp_en && serr_en;

   ppg_perr_drive u_perr (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (perr_fire),
      .perr_oe (perr_oe),
      .perr_o  (perr_o)
   );

   ppg_serr_drive u_serr (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (serr_fire),
      .serr_oe (serr_oe),
      .serr_o  (serr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             parity_err_stat <= 1'b0;
      else if (any_err)       parity_err_stat <= 1'b1;
      else if (perr_stat_clr) parity_err_stat <= 1'b0;
   end

   assert_serr_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |-> $past(par_resp_en && serr_en));
   assert_serr_low_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |-> !serr_o);
   assert_perr_from_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_oe && !perr_o) |-> $past(data_phase, 2) && $past(par_resp_en));
   assert_stat_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(parity_err_stat) |-> $past(any_err));
   assert_float_in_reset_R9: assert property (@(posedge clk)
      !rst_n |-> !perr_oe && !serr_oe);
endmodule

// File: tb/pci_parity_guard_tb_top.sv
module pci_parity_guard_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RAND_STEPS = 4000;
   localparam int WD_LIMIT   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_phase = 1'b0, data_phase = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;
   logic        par = 1'b0, par_resp_en = 1'b0, serr_en = 1'b0, perr_stat_clr = 1'b0;
   logic        perr_oe, perr_o, serr_oe, serr_o, parity_err_stat;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench reference state
   int   p_kind = 0;
   bit   p_par = 0, p_spec = 0, spec_tx = 0;
   bit   prev_low = 0;
   bit   e_perr_oe = 0, e_perr_o = 1, e_serr_oe = 0, e_stat = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pci_parity_guard dut_i (
      .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .data_phase(data_phase),
      .ad(ad), .cbe_n(cbe_n), .par(par), .par_resp_en(par_resp_en),
      .serr_en(serr_en), .perr_stat_clr(perr_stat_clr),
      .perr_oe(perr_oe), .perr_o(perr_o), .serr_oe(serr_oe), .serr_o(serr_o),
      .parity_err_stat(parity_err_stat)
   );

   function automatic bit even_fold(input logic [31:0] a, input logic [3:0] c);
      return ^{a, c};
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_outputs();
      chk(e_perr_oe && e_perr_o ? "R6" : "R4", perr_oe, e_perr_oe, "perr_oe");
      if (e_perr_oe) chk(e_perr_o ? "R6" : "R5", perr_o, e_perr_o, "perr_o");
      chk("R2", serr_oe, e_serr_oe, "serr_oe");
      if (serr_oe === 1'b1) chk("R3", serr_o, 1'b0, "serr_o");
      chk("R8", parity_err_stat, e_stat, "parity_err_stat");
   endtask

   task automatic step(input bit ap, input bit dp, input logic [3:0] cmd, input bit bad,
                       input bit resp, input bit sen, input bit clr);
      bit err, nlow, nserr;
      @(negedge clk);
      check_outputs();
      addr_phase    = ap;
      data_phase    = dp & ~ap;
      ad            = $urandom;
      cbe_n         = ap ? cmd : 4'($urandom);
      par           = p_par ^ bad;
      par_resp_en   = resp;
      serr_en       = sen;
      perr_stat_clr = clr;
      // R1: error only when the previous clock was a phase and parity mismatches
      err   = (p_kind != 0) && bad;
      nlow  = err && (p_kind == 2) && resp && !p_spec;
      nserr = err && (p_kind == 1) && resp && sen;
      e_perr_oe = nlow || prev_low;
      e_perr_o  = !nlow;
      prev_low  = nlow;
      e_serr_oe = nserr;
      e_stat    = err ? 1'b1 : (clr ? 1'b0 : e_stat);
      if (ap) begin
         p_kind  = 1;
         p_spec  = 0;
         spec_tx = (cmd == 4'b0001);
      end else if (dp) begin
         p_kind = 2;
         p_spec = spec_tx;
      end else begin
         p_kind = 0;
         p_spec = 0;
      end
      p_par = even_fold(ad, cbe_n);
   endtask

   initial begin : watchdog
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      // R9: errors and activity during reset are ignored, outputs floated
      par_resp_en = 1'b1;
      serr_en     = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R9", perr_oe, 1'b0, "perr_oe in reset");
         chk("R9", serr_oe, 1'b0, "serr_oe in reset");
         addr_phase = i[0];
         data_phase = ~i[0];
         ad    = $urandom;
         cbe_n = 4'($urandom);
         par   = 1'($urandom);
      end
      @(negedge clk);
      rst_n = 1'b1;
      addr_phase = 1'b0;
      data_phase = 1'b0;
      // first post-reset clock: par may mismatch, but no phase is pending
      step(0, 0, 4'h0, 1, 1, 1, 0);
      step(0, 0, 4'h0, 0, 1, 1, 0);
      chk("R9", parity_err_stat, 1'b0, "stat after reset");

      // R2/R3: address parity error with both enables
      step(1, 0, 4'h6, 0, 1, 1, 0);
      step(0, 1, 4'h0, 1, 1, 1, 0);
      // R2: SERR enable off -> no pulse, status still set (R8)
      step(1, 0, 4'h7, 0, 1, 0, 0);
      step(0, 1, 4'h0, 1, 1, 0, 0);
      // R5/R6: three back-to-back bad data phases then clean
      step(0, 1, 4'h0, 0, 1, 0, 0);
      step(0, 1, 4'h0, 1, 1, 0, 0);
      step(0, 1, 4'h0, 1, 1, 0, 0);
      step(0, 0, 4'h0, 1, 1, 0, 0);
      step(0, 0, 4'h0, 0, 1, 0, 1);
      step(0, 0, 4'h0, 0, 1, 0, 0);
      step(0, 0, 4'h0, 0, 1, 0, 0);
      // R4: response enable off -> no PERR, status set
      step(0, 1, 4'h0, 0, 0, 1, 0);
      step(0, 0, 4'h0, 1, 0, 1, 0);
      // R8: set and clear on the same clock, set wins
      step(0, 1, 4'h0, 0, 1, 1, 1);
      step(0, 0, 4'h0, 1, 1, 1, 1);
      step(0, 0, 4'h0, 0, 1, 1, 1);
      step(0, 0, 4'h0, 0, 1, 1, 0);
      // R7: special transaction data phases exempt, next transaction is not
      step(1, 0, 4'b0001, 0, 1, 1, 0);
      step(0, 1, 4'h0, 0, 1, 1, 0);
      step(0, 1, 4'h0, 1, 1, 1, 0);
      step(1, 0, 4'h3, 1, 1, 1, 0);
      step(0, 1, 4'h0, 0, 1, 1, 0);
      step(0, 0, 4'h0, 1, 1, 1, 0);
      step(0, 0, 4'h0, 0, 1, 1, 0);
      step(0, 0, 4'h0, 0, 1, 1, 0);

      // constrained random traffic (R1..R8)
      for (int n = 0; n < RAND_STEPS; n++) begin
         int  sel;
         logic [3:0] c;
         sel = $urandom_range(0, 9);
         c   = ($urandom_range(0, 3) == 0) ? 4'b0001 : 4'($urandom);
         step(sel < 2, sel >= 2 && sel < 8, c,
              $urandom_range(0, 5) == 0,
              $urandom_range(0, 7) != 0,
              $urandom_range(0, 3) != 0,
              $urandom_range(0, 7) == 0);
      end
      step(0, 0, 4'h0, 0, 1, 1, 0);
      step(0, 0, 4'h0, 0, 1, 1, 0);
      @(negedge clk);
      check_outputs();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule